// File: doc/BRIEF.md
# Packed BCD Sum Correction Unit

This unit sits directly behind an 8-bit binary adder. It turns the sum of two packed-decimal bytes into a valid packed-decimal result. Each byte carries two decimal digits, one in each 4-bit nibble. The codes ten through fifteen are never legal digits.

The unit takes three inputs from the preceding add: the raw sum byte, the carry out of bit 7 and the carry out of bit 3. From these it picks a correction of 0x00, 0x06, 0x60 or 0x66 and adds it to the raw sum.

It outputs the corrected byte and a carry that stands for the hundreds digit. It also outputs a negative flag and a zero flag. Results are registered and appear one clock after an input is marked valid. The inputs are meaningful only when they come from a plain add, an add with carry-in, or an add of two accumulators. They are never meaningful after a subtraction.

Top module: `bcd_sum_fixup`

## Requirements
- R1: While `rst_n` is low, and on the first clock after its release with `in_valid` low, `out_valid`, `adj_sum`, `hund_carry`, `flag_neg` and `flag_zero` are all 0.
- R2: A cycle with `in_valid` high produces `out_valid` high on the next clock edge. A cycle with `in_valid` low produces `out_valid` low on the next edge.
- R3: The low nibble is raised by 6 when the raw low nibble is above 9 or `add_half` is 1. A raw low nibble of 9 or less with `add_half` at 0 passes through unchanged.
- R4: The high nibble is raised by 6 (0x60 added to the byte) in three cases: the raw high nibble is above 9, `add_carry` is 1, or the raw high nibble is exactly 9 while the raw low nibble is above 9.
- R5: `hund_carry` is 1 when `add_carry` was 1 or when adding the correction carries out of bit 7. Otherwise it is 0.
- R6: `flag_neg` equals bit 7 of the corrected byte.
- R7: `flag_zero` is 1 exactly when the corrected byte is 0x00.
- R8: Take any two valid packed-decimal bytes a and b and a carry-in c in {0,1}, fed through a binary add. The unit then returns the two low decimal digits of a+b+c as packed BCD, high digit in bits 7:4, and sets `hund_carry` when a+b+c is 100 or more.
- R9: While `in_valid` is low, `adj_sum`, `hund_carry`, `flag_neg` and `flag_zero` hold their previous values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw sum and flags are valid this cycle |
| raw_sum | input | 8 | Binary sum byte from the adder |
| add_carry | input | 1 | Carry out of bit 7 of the add |
| add_half | input | 1 | Carry out of bit 3 of the add |
| out_valid | output | 1 | Corrected result valid |
| adj_sum | output | 8 | Corrected packed-BCD byte |
| hund_carry | output | 1 | Hundreds digit of the decimal sum |
| flag_neg | output | 1 | Bit 7 of the corrected byte |
| flag_zero | output | 1 | Corrected byte is zero |

## Verification
A wrong correction choice appears at `adj_sum` one clock after the input is accepted. Typical symptoms are a digit code above 9, or a digit off by six. Swept over every digit pair with both carry-in values, such an error shows up within the first pair that takes the wrong path.

A stuck or wrongly merged carry shows as a hundreds digit that disagrees with the decimal sum on the same cycle. A corrupted result register that fails to hold shows at the very next idle cycle, because the outputs must stay frozen then.

// File: rtl/bcd_fix_pkg.sv
package bcd_fix_pkg;

    parameter int DIGIT_W = 4;
    parameter int NUM_DIG = 2;
    localparam int BYTE_W = DIGIT_W * NUM_DIG;
    localparam int DIG_MAX = 9;
    localparam int CORR = (1 << DIGIT_W) - (DIG_MAX + 1);

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  vld;
        byte_t res;
        logic  cy;
        logic  neg;
        logic  zero;
    } fix_state_t;

endpackage

// File: rtl/bcd_nib_check.sv
module bcd_nib_check
    import bcd_fix_pkg::*;
(
    input  digit_t nib,
    output logic   above_max,
    output logic   at_max
);
    localparam digit_t LIMIT = digit_t'(DIG_MAX);

    always_comb begin
        above_max = (nib > LIMIT);
        at_max    = (nib == LIMIT);
    end
endmodule

// File: rtl/bcd_fix_select.sv
module bcd_fix_select
    import bcd_fix_pkg::*;
(
    input  logic [NUM_DIG-1:0] nib_over,
    input  logic [NUM_DIG-1:0] nib_nine,
    input  logic               half_in,
    input  logic               carry_in,
    output byte_t              factor
);
    localparam digit_t SIX = digit_t'(CORR);

    logic fix_lo;
    logic fix_hi;

    always_comb begin
        fix_lo = nib_over[0] | half_in;
        fix_hi = nib_over[NUM_DIG-1] | carry_in
               | (nib_nine[NUM_DIG-1] & nib_over[0]);
        factor = '0;
        factor[DIGIT_W-1:0]      = fix_lo ? SIX : '0;
        factor[BYTE_W-1 -: DIGIT_W] = fix_hi ? SIX : '0;
    end
endmodule

// File: rtl/bcd_sum_fixup.sv
module bcd_sum_fixup
    import bcd_fix_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] raw_sum,
    input  logic       add_carry,
    input  logic       add_half,
    output logic       out_valid,
    output logic [7:0] adj_sum,
    output logic       hund_carry,
    output logic       flag_neg,
    output logic       flag_zero
);
    logic [NUM_DIG-1:0] over_v;
    logic [NUM_DIG-1:0] nine_v;
    byte_t              factor;
    logic [BYTE_W:0]    wide_sum;
    fix_state_t         st_d;
    fix_state_t         st_q;

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_nib
        bcd_nib_check u_chk (
            .nib       (raw_sum[g*DIGIT_W +: DIGIT_W]),
            .above_max (over_v[g]),
            .at_max    (nine_v[g])
        );
    end

    bcd_fix_select u_sel (
        .nib_over (over_v),
        .nib_nine (nine_v),
        .half_in  (add_half),
        .carry_in (add_carry),
        .factor   (factor)
    );

    always_comb begin
        st_d     = st_q;
        wide_sum = {1'b0, raw_sum} + {1'b0, factor};
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res  = wide_sum[BYTE_W-1:0];
            st_d.cy   = add_carry | wide_sum[BYTE_W];
            st_d.neg  = wide_sum[BYTE_W-1];
            st_d.zero = (wide_sum[BYTE_W-1:0] == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign adj_sum    = st_q.res;
    assign hund_carry = st_q.cy;
    assign flag_neg   = st_q.neg;
    assign flag_zero  = st_q.zero;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(adj_sum) && $stable(hund_carry)));
    assert_carry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && add_carry) |=> hund_carry);
    assert_low_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !add_half && raw_sum[3:0] <= 4'd9)
        |=> (adj_sum[3:0] == $past(raw_sum[3:0])));
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_zero == (adj_sum == 8'h00)));
endmodule

// File: tb/bcd_sum_fixup_test.sv
`timescale 1ns/1ps
module bcd_sum_fixup_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] raw_sum = 8'h00;
    logic       add_carry = 1'b0;
    logic       add_half = 1'b0;
    logic       out_valid;
    logic [7:0] adj_sum;
    logic       hund_carry;
    logic       flag_neg;
    logic       flag_zero;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcd_sum_fixup uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .raw_sum(raw_sum),
        .add_carry(add_carry), .add_half(add_half), .out_valid(out_valid),
        .adj_sum(adj_sum), .hund_carry(hund_carry), .flag_neg(flag_neg),
        .flag_zero(flag_zero)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int v);
        return {4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    // drive the binary add of two BCD values at negedge; result checked next negedge
    task automatic apply(input int a, input int b, input bit cin, input string req);
        logic [8:0] s;
        logic [4:0] h;
        logic [7:0] ba;
        logic [7:0] bb;
        int dec;
        ba = to_bcd(a);
        bb = to_bcd(b);
        s  = {1'b0, ba} + {1'b0, bb} + 9'(cin);
        h  = {1'b0, ba[3:0]} + {1'b0, bb[3:0]} + 5'(cin);
        @(negedge clk);
        in_valid  = 1'b1;
        raw_sum   = s[7:0];
        add_carry = s[8];
        add_half  = h[4];
        @(negedge clk);
        in_valid = 1'b0;
        dec = a + b + int'(cin);
        chk({req, " result"}, adj_sum, to_bcd(dec % 100));
        chk({req, " hundreds"}, hund_carry, dec >= 100);
        chk({req, " valid"}, out_valid, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid", out_valid, 0);
        chk("R1 sum", adj_sum, 0);
        chk("R1 flags", {hund_carry, flag_neg, flag_zero}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {out_valid, adj_sum, hund_carry}, 0);
    endtask

    task automatic t_corners();
        apply(99, 99, 1'b1, "R8 max");
        chk("R6 neg max", flag_neg, 1);
        apply(50, 50, 1'b0, "R7 hundred");
        chk("R7 zero on 100", flag_zero, 1);
        apply(0, 0, 1'b0, "R7 zero");
        chk("R7 zero flag", flag_zero, 1);
        apply(49, 49, 1'b0, "R3 half carry");
        chk("R6 neg 98", flag_neg, 1);
        apply(5, 5, 1'b0, "R3 low over nine");
        chk("R7 nonzero", flag_zero, 0);
        apply(45, 55, 1'b0, "R4 nine with low fix");
        apply(90, 20, 1'b0, "R4 high over nine");
        apply(80, 90, 1'b0, "R4 carry in set");
        apply(60, 60, 1'b0, "R5 generated carry");
        apply(12, 34, 1'b0, "R3 no fix");
        chk("R6 neg 46", flag_neg, 0);
    endtask

    task automatic t_direct();
        // raw inputs not from a sum: 0x9A, no flags -> 0x00 with carry (R4, R5)
        @(negedge clk);
        in_valid = 1'b1; raw_sum = 8'h9A; add_carry = 1'b0; add_half = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 9A", adj_sum, 8'h00);
        chk("R5 9A carry", hund_carry, 1);
        // 0x12 with carry and half set -> 0x78, carry kept
        @(negedge clk);
        in_valid = 1'b1; raw_sum = 8'h12; add_carry = 1'b1; add_half = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 R4 12", adj_sum, 8'h78);
        chk("R5 carry kept", hund_carry, 1);
    endtask

    task automatic t_hold_and_latency();
        logic [7:0] prev;
        apply(37, 48, 1'b0, "R2 setup");
        prev = adj_sum;
        raw_sum = 8'hFF; add_carry = 1'b1; add_half = 1'b1;
        @(negedge clk);
        chk("R2 valid drops", out_valid, 0);
        chk("R9 sum held", adj_sum, prev);
        chk("R9 carry held", hund_carry, 0);
        @(negedge clk);
        chk("R9 still held", adj_sum, prev);
    endtask

    task automatic t_sweep();
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 100; a++)
                for (int b = 0; b < 100; b++)
                    apply(a, b, c[0], "R8 sweep");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_corners();
        t_direct();
        t_hold_and_latency();
        t_sweep();
        finish_run();
    end

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end
endmodule